// File: doc/BRIEF.md
# Condition Flag Generator

This block turns the side results of an integer operation into five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). For each operation it takes the result word, the carry or borrow out, the overflow indication, the operand size (byte, word or long) and an operation class. N and Z are worked out from the low 8, 16 or 32 bits of the result, depending on the operand size. The extend flag is kept apart from carry. It takes the carry value only on arithmetic operations. It holds its value on logical and move operations. It is loaded from an explicit input on the extend-load class.

Flag updates arrive as a valid/ready stream. The update is accepted on a clock edge where both `upd_valid` and `upd_ready` are high. The block lowers `upd_ready` only in a cycle where the register write port is active, because a direct write takes priority over an update. An update offered in that cycle is not taken, and the producer holds it until ready returns. The flag byte is readable at all times. Bits 4..0 of the flag byte hold X, N, Z, V, C in that order, and bits 7..5 read as zero.

Top module: `ccr_unit`

## Requirements
- R1: While `rst_n` is low, `rd_data` reads 8'h00 and all flags are clear.
- R2: On an accepted update, N (bit 3) is set to bit 7, 15 or 31 of the result for size code 0 (byte), 1 (word) or 2/3 (long).
- R3: On an accepted update, Z (bit 2) is set when the low 8, 16 or 32 bits of the result (chosen by size) are all zero. Result bits above the operand size have no effect.
- R4: On an accepted update of class 0 (arithmetic), V (bit 1) takes `upd_ovf` and C (bit 0) takes `upd_carry`.
- R5: On an accepted arithmetic update, X (bit 4) takes the same value as the new C.
- R6: On an accepted update of class 1 (logical) or class 2 (move), V and C are cleared and X keeps its previous value.
- R7: On an accepted update of class 3 (extend load), X takes `upd_xval`, V and C are cleared, and N and Z follow the result.
- R8: When `wr_en` is high, the flags are loaded from `wr_data[4:0]` at the clock edge. `rd_data[7:5]` always reads zero.
- R9: While `wr_en` is high, `upd_ready` is low and an offered update has no effect on the flags. Otherwise `upd_ready` is high.
- R10: When neither `wr_en` nor `upd_valid` is high, the flags keep their value.
- R11: The flags produced by an accepted update or a write appear on `rd_data` in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Flag update offered |
| upd_ready | output | 1 | Update can be accepted this cycle |
| upd_result | input | 32 | Operation result |
| upd_carry | input | 1 | Carry or borrow out at the operand size |
| upd_ovf | input | 1 | Overflow at the operand size |
| upd_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| upd_cls | input | 2 | 0 arithmetic, 1 logical, 2 move, 3 extend load |
| upd_xval | input | 1 | Extend value used by class 3 |
| wr_en | input | 1 | Direct write of the flag byte |
| wr_data | input | 8 | Byte to write; bits 7..5 ignored |
| rd_data | output | 8 | Current flag byte |

## Verification
The flag register is the only state in the block, so a wrong internal value shows up on `rd_data` one cycle after the edge that caused it. It stays there until the next accepted update or write. A wrong X is the slowest to show, because logical and move updates carry it forward without change. For that reason the stimulus follows arithmetic updates with logical and move updates before it overwrites X. A handshake fault is visible at once on `upd_ready`. An update that is accepted when it should be dropped shows on `rd_data` in the next cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } opsize_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_MOVE  = 2'd2,
    CLS_XLOAD = 2'd3
  } opcls_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/ccr_size_view.sv
module ccr_size_view #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  ccr_pkg::opsize_e  size,
  output logic              msb,
  output logic              zero
);
  localparam int NSZ = 3;

  logic [NSZ-1:0] msb_k;
  logic [NSZ-1:0] zero_k;

  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    localparam int W = 8 << k;
    if (W <= DATA_W) begin : g_fit
      assign msb_k[k]  = result[W-1];
      assign zero_k[k] = ~|result[W-1:0];
    end else begin : g_clip
      assign msb_k[k]  = result[DATA_W-1];
      assign zero_k[k] = ~|result;
    end
  end

  always_comb begin
    unique case (size)
      ccr_pkg::SZ_BYTE: begin msb = msb_k[0]; zero = zero_k[0]; end
      ccr_pkg::SZ_WORD: begin msb = msb_k[1]; zero = zero_k[1]; end
      default:          begin msb = msb_k[2]; zero = zero_k[2]; end
    endcase
  end
endmodule

// File: rtl/ccr_next.sv
module ccr_next (
  input  ccr_pkg::flags_t cur,
  input  logic            msb,
  input  logic            zero,
  input  logic            carry,
  input  logic            ovf,
  input  logic            xval,
  input  ccr_pkg::opcls_e cls,
  output ccr_pkg::flags_t nxt
);
  always_comb begin
    nxt.n = msb;
    nxt.z = zero;
    unique case (cls)
      ccr_pkg::CLS_ARITH: begin
        nxt.v = ovf;
        nxt.c = carry;
        nxt.x = carry;
      end
      ccr_pkg::CLS_XLOAD: begin
        nxt.v = 1'b0;
        nxt.c = 1'b0;
        nxt.x = xval;
      end
      default: begin
        nxt.v = 1'b0;
        nxt.c = 1'b0;
        nxt.x = cur.x;
      end
    endcase
  end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [DATA_W-1:0] upd_result,
  input  logic              upd_carry,
  input  logic              upd_ovf,
  input  logic [1:0]        upd_size,
  input  logic [1:0]        upd_cls,
  input  logic              upd_xval,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);
  import ccr_pkg::*;

  localparam int PAD_W = BYTE_W - FLAG_W;

  flags_t flags_q;
  flags_t flags_nxt;
  logic   res_msb;
  logic   res_zero;
  logic   accept;

  assign upd_ready = ~wr_en;
  assign accept    = upd_valid & upd_ready;

  ccr_size_view #(.DATA_W(DATA_W)) i_view (
    .result (upd_result),
    .size   (opsize_e'(upd_size)),
    .msb    (res_msb),
    .zero   (res_zero)
  );

  ccr_next i_next (
    .cur   (flags_q),
    .msb   (res_msb),
    .zero  (res_zero),
    .carry (upd_carry),
    .ovf   (upd_ovf),
    .xval  (upd_xval),
    .cls   (opcls_e'(upd_cls)),
    .nxt   (flags_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (wr_en)  flags_q <= flags_t'(wr_data[FLAG_W-1:0]);
    else if (accept) flags_q <= flags_nxt;
  end

  assign rd_data = {{PAD_W{1'b0}}, flags_q};
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_valid,
  input logic       upd_ready,
  input logic [1:0] upd_cls,
  input logic       upd_xval,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data
);
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000); // R8
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[4:0] == $past(wr_data[4:0])); // R8
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !upd_ready); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_valid) |=> $stable(rd_data)); // R10
  AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_cls == 2'd0) |=> rd_data[4] == rd_data[0]); // R5
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && (upd_cls == 2'd1 || upd_cls == 2'd2))
      |=> (rd_data[4] == $past(rd_data[4]) && rd_data[1:0] == 2'b00)); // R6
  AST_XLOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_cls == 2'd3)
      |=> (rd_data[4] == $past(upd_xval) && rd_data[1:0] == 2'b00)); // R7
endmodule

bind ccr_unit ccr_unit_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_ready (upd_ready),
  .upd_cls   (upd_cls),
  .upd_xval  (upd_xval),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data)
);

// File: tb/test_ccr_unit.sv
`timescale 1ns/1ps
module test_ccr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_result = '0;
  logic        upd_carry = 1'b0;
  logic        upd_ovf = 1'b0;
  logic [1:0]  upd_size = '0;
  logic [1:0]  upd_cls = '0;
  logic        upd_xval = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R1";
  logic [7:0] exp_q = 8'h00;

  always #10 clk = ~clk;

  ccr_unit i_ccr_unit (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_result(upd_result), .upd_carry(upd_carry), .upd_ovf(upd_ovf),
    .upd_size(upd_size), .upd_cls(upd_cls), .upd_xval(upd_xval),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  // Behavioural reference model
  function automatic logic [7:0] model_next(logic [7:0] cur);
    int w;
    logic [31:0] m;
    logic n, z, v, c, x;
    w = (upd_size == 2'd0) ? 8 : (upd_size == 2'd1) ? 16 : 32;
    m = (w == 32) ? upd_result : (upd_result & ((32'd1 << w) - 1));
    n = m[w-1];
    z = (m == 0);
    x = cur[4];
    v = 0;
    c = 0;
    if (upd_cls == 2'd0) begin v = upd_ovf; c = upd_carry; x = upd_carry; end
    else if (upd_cls == 2'd3) x = upd_xval;
    return {3'b000, x, n, z, v, c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_q <= 8'h00;
    else if (wr_en) exp_q <= wr_data & 8'h1F;
    else if (upd_valid) exp_q <= model_next(exp_q);
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (rd_data !== exp_q) begin
        n_bad++;
        $display("FAIL %s rd_data=%h expected=%h at %0t", tag, rd_data, exp_q, $time);
      end
      n_cmp++;
      if (upd_ready !== !wr_en) begin
        n_bad++;
        $display("FAIL R9 upd_ready=%b expected=%b at %0t", upd_ready, !wr_en, $time);
      end
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    upd_valid = 0; wr_en = 0;
    upd_result = $urandom; upd_carry = 1; upd_ovf = 1; upd_xval = 1;
  endtask

  task automatic upd(logic [31:0] r, logic [1:0] sz, logic [1:0] cl,
                     logic cy, logic ov, logic xv);
    @(negedge clk); #1;
    wr_en = 0; upd_valid = 1; upd_result = r; upd_size = sz; upd_cls = cl;
    upd_carry = cy; upd_ovf = ov; upd_xval = xv;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); #1;
    upd_valid = 0; wr_en = 1; wr_data = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    tag = "R8"; wr(8'hFF); wr(8'h00); wr(8'hEA);
    tag = "R2"; upd(32'hFFFF_FF80, 2'd0, 2'd0, 1, 1, 0);
    upd(32'h0000_8000, 2'd1, 2'd0, 0, 0, 0);
    upd(32'h8000_0000, 2'd3, 2'd0, 0, 1, 0);
    upd(32'h0000_0080, 2'd1, 2'd0, 0, 0, 0);
    tag = "R3"; upd(32'h1234_5600, 2'd0, 2'd0, 0, 0, 0);
    upd(32'hFFFF_0000, 2'd1, 2'd0, 1, 0, 0);
    upd(32'hFFFF_0000, 2'd2, 2'd0, 0, 0, 0);
    tag = "R4"; upd(32'h0000_0001, 2'd2, 2'd0, 1, 1, 0);
    tag = "R5"; upd(32'h0000_0001, 2'd2, 2'd0, 1, 0, 0);
    tag = "R6"; upd(32'h0000_0000, 2'd2, 2'd1, 0, 1, 0);
    upd(32'h0000_00F0, 2'd0, 2'd2, 1, 1, 0);
    upd(32'h0000_0000, 2'd0, 2'd0, 0, 0, 0);
    upd(32'hFFFF_FFFF, 2'd2, 2'd1, 1, 1, 1);
    tag = "R7"; upd(32'h0000_0000, 2'd1, 2'd3, 1, 1, 1);
    upd(32'h0000_8000, 2'd1, 2'd3, 1, 1, 0);
    tag = "R9"; wr(8'h15);
    #0 upd_valid = 1; upd_result = 32'h8000_0000; upd_cls = 2'd0; upd_carry = 1;
    wr(8'h0A);
    #0 upd_valid = 1;
    tag = "R10"; idle(); idle(); idle();
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) wr(8'($urandom));
      else if (k == 1) idle();
      else upd($urandom, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    idle(); idle();
    finish_run();
  end
endmodule